// File: doc/BRIEF.md
# Cache Write Flow Sequencer

This block sits between one processor core and its private data cache and carries each processor write through the system write flow. A write request arrives together with the result of the local tag lookup. If the lookup hits, the write is acknowledged to the core straight away. If it misses, the sequencer sends a snoop write request to the other core's cache and waits for the answer. If the snoop hits, the write is acknowledged once the snoop answer is back. If both the local lookup and the snoop miss, the sequencer sends a full-line write request to the interconnect, waits for the interconnect's write response (the interconnect reads the line from memory in between), and then acknowledges the core.

Every message the block emits is a single-cycle valid pulse carrying a command, a tag, a sequence number, an address and a data field. The tag identifies the originating core, so the interconnect can tell the two cores' traffic apart. The sequence number is drawn once per flow from a local counter and is repeated on every message of that flow. Only one flow is open at a time. While a flow waits on the snoop or on the interconnect, the core is held off with a ready signal. Two status outputs record which branch the current flow took.

Top module: `wflow_seq`

## Requirements
- R1: Starting one cycle after reset is released, `cpu_req_ready` is 1, every outgoing valid is 0, and both status outputs are 0.
- R2: A request accepted with `cpu_req_hit`=1 makes `cpu_rsp_valid` high in the next cycle with command 0x12 and the request's address and data echoed, and neither the snoop nor the interconnect request is raised for that flow.
- R3: A request accepted with `cpu_req_hit`=0 makes `snp_req_valid` high in the next cycle with command 0x21 and the request's address and data, and `snp_req_peer` equals 1 minus `CORE_ID`.
- R4: While a snoop is outstanding, `snp_rsp_valid` with `snp_rsp_hit`=1 makes `cpu_rsp_valid` (command 0x12) high in the next cycle, and no interconnect request is sent.
- R5: While a snoop is outstanding, `snp_rsp_valid` with `snp_rsp_hit`=0 makes `bus_req_valid` high in the next cycle with command 0x31 and the request address. Its 512-bit data holds the write data in 32-bit word number addr[5:2] (bits word*32 and up) and zeros elsewhere. A later `bus_rsp_valid` makes `cpu_rsp_valid` (0x12) high in the next cycle.
- R6: The tag field of every emitted message equals `CORE_ID`.
- R7: The first flow after reset uses sequence number 0, and each accepted flow uses the previous flow's number plus 1, modulo 256. Every message of a flow carries that flow's number.
- R8: `cpu_req_ready` is 0 from the cycle after a missing request is accepted until the cycle after the flow's response. A request presented in that window is ignored: it is not accepted and does not use up a sequence number.
- R9: `st_local_hit` takes the value of `cpu_req_hit` in the cycle after an accept. `st_snoop_hit` is cleared in the cycle after an accept and takes `snp_rsp_hit` in the cycle after a snoop answer.
- R10: Each outgoing valid is high for exactly one cycle per message, and at most one of the three outgoing valids is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Core write request present |
| cpu_req_ready | output | 1 | Sequencer can accept a request |
| cpu_req_addr | input | 32 | Write address |
| cpu_req_data | input | 32 | Write data |
| cpu_req_hit | input | 1 | Local tag lookup result for this request |
| snp_req_valid | output | 1 | Snoop write request pulse |
| snp_req_cmd | output | 8 | Snoop command (0x21) |
| snp_req_tag | output | 8 | Originator identity |
| snp_req_seq | output | 8 | Flow sequence number |
| snp_req_addr | output | 32 | Snoop address |
| snp_req_data | output | 32 | Snoop data |
| snp_req_peer | output | 8 | Index of the snooped cache |
| snp_rsp_valid | input | 1 | Snoop answer present |
| snp_rsp_hit | input | 1 | Snoop answer hit flag |
| bus_req_valid | output | 1 | Interconnect write request pulse |
| bus_req_cmd | output | 8 | Interconnect command (0x31) |
| bus_req_tag | output | 8 | Originator identity |
| bus_req_seq | output | 8 | Flow sequence number |
| bus_req_addr | output | 32 | Write address |
| bus_req_data | output | 512 | Full line with the write word placed |
| bus_rsp_valid | input | 1 | Interconnect write response present |
| cpu_rsp_valid | output | 1 | Write response pulse to the core |
| cpu_rsp_cmd | output | 8 | Response command (0x12) |
| cpu_rsp_tag | output | 8 | Originator identity |
| cpu_rsp_seq | output | 8 | Flow sequence number |
| cpu_rsp_addr | output | 32 | Echoed address |
| cpu_rsp_data | output | 32 | Echoed data |
| st_local_hit | output | 1 | Branch status: local lookup hit |
| st_snoop_hit | output | 1 | Branch status: snoop hit |

## Verification
The bench builds the block with `CORE_ID` set to 1, so the peer index it expects is 0 and not the reset value of a register. It also uses a tag value that is nonzero. The widths stay at their defaults, 8-bit sequence numbers and a 64-byte line. At these widths the bench can run 256 hit flows in a row and see the sequence number wrap. It can also place write words at both ends of the line to check where the word lands.

// File: rtl/wflow_pkg.sv
package wflow_pkg;
  localparam logic [7:0] CMD_WR_RSP  = 8'h12;
  localparam logic [7:0] CMD_SNP_WR  = 8'h21;
  localparam logic [7:0] CMD_BUS_WR  = 8'h31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_BUS   = 2'd2
  } flow_state_t;
endpackage

// File: rtl/wflow_seqid.sv
module wflow_seqid #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic [SEQ_W-1:0] cur
);
  logic [SEQ_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (take) cnt_q <= cnt_q + 1'b1;
  end

  assign cur = cnt_q;
endmodule

// File: rtl/wflow_link_out.sv
module wflow_link_out #(
  parameter int CMD_W  = 8,
  parameter int TAG_W  = 8,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic              valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     data_o
);
  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o  <= '0;
      tag_o  <= '0;
      seq_o  <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else if (load) begin
      cmd_o  <= cmd_i;
      tag_o  <= tag_i;
      seq_o  <= seq_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/wflow_seq.sv
module wflow_seq #(
  parameter int CORE_ID    = 0,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int CMD_W      = 8,
  parameter int TAG_W      = 8,
  parameter int SEQ_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_req_valid,
  output logic                      cpu_req_ready,
  input  logic [ADDR_W-1:0]         cpu_req_addr,
  input  logic [DATA_W-1:0]         cpu_req_data,
  input  logic                      cpu_req_hit,
  output logic                      snp_req_valid,
  output logic [CMD_W-1:0]          snp_req_cmd,
  output logic [TAG_W-1:0]          snp_req_tag,
  output logic [SEQ_W-1:0]          snp_req_seq,
  output logic [ADDR_W-1:0]         snp_req_addr,
  output logic [DATA_W-1:0]         snp_req_data,
  output logic [TAG_W-1:0]          snp_req_peer,
  input  logic                      snp_rsp_valid,
  input  logic                      snp_rsp_hit,
  output logic                      bus_req_valid,
  output logic [CMD_W-1:0]          bus_req_cmd,
  output logic [TAG_W-1:0]          bus_req_tag,
  output logic [SEQ_W-1:0]          bus_req_seq,
  output logic [ADDR_W-1:0]         bus_req_addr,
  output logic [LINE_BYTES*8-1:0]   bus_req_data,
  input  logic                      bus_rsp_valid,
  output logic                      cpu_rsp_valid,
  output logic [CMD_W-1:0]          cpu_rsp_cmd,
  output logic [TAG_W-1:0]          cpu_rsp_tag,
  output logic [SEQ_W-1:0]          cpu_rsp_seq,
  output logic [ADDR_W-1:0]         cpu_rsp_addr,
  output logic [DATA_W-1:0]         cpu_rsp_data,
  output logic                      st_local_hit,
  output logic                      st_snoop_hit
);
  import wflow_pkg::*;

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / DATA_W;
  localparam int OFS_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int OFS_LO = $clog2(DATA_W / 8);
  localparam logic [TAG_W-1:0] MY_TAG   = TAG_W'(CORE_ID);
  localparam logic [TAG_W-1:0] PEER_TAG = TAG_W'(1 - CORE_ID);

  flow_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [SEQ_W-1:0]  seq_cur;
  logic              loc_hit_q, snp_hit_q;
  logic              accept, snp_done, load_cpu, load_snp, load_bus;
  logic [ADDR_W-1:0] rsp_addr;
  logic [DATA_W-1:0] rsp_data;
  logic [SEQ_W-1:0]  rsp_seq;
  logic [LINE_W-1:0] line;

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign snp_done      = (state_q == ST_SNOOP) && snp_rsp_valid;
  assign load_snp      = accept && !cpu_req_hit;
  assign load_bus      = snp_done && !snp_rsp_hit;
  assign load_cpu      = (accept && cpu_req_hit) || (snp_done && snp_rsp_hit) ||
                         ((state_q == ST_BUS) && bus_rsp_valid);

  assign rsp_addr = accept ? cpu_req_addr : addr_q;
  assign rsp_data = accept ? cpu_req_data : data_q;
  assign rsp_seq  = accept ? seq_cur : seq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      seq_q     <= '0;
      loc_hit_q <= 1'b0;
      snp_hit_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q    <= cpu_req_addr;
        data_q    <= cpu_req_data;
        seq_q     <= seq_cur;
        loc_hit_q <= cpu_req_hit;
        snp_hit_q <= 1'b0;
        state_q   <= cpu_req_hit ? ST_IDLE : ST_SNOOP;
      end else if (snp_done) begin
        snp_hit_q <= snp_rsp_hit;
        state_q   <= snp_rsp_hit ? ST_IDLE : ST_BUS;
      end else if ((state_q == ST_BUS) && bus_rsp_valid) begin
        state_q   <= ST_IDLE;
      end
    end
  end

  assign st_local_hit = loc_hit_q;
  assign st_snoop_hit = snp_hit_q;
  assign snp_req_peer = PEER_TAG;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign line[w*DATA_W +: DATA_W] =
        (addr_q[OFS_LO +: OFS_W] == OFS_W'(w)) ? data_q : '0;
    end
  endgenerate

  wflow_seqid #(.SEQ_W(SEQ_W)) seqid_i (
    .clk(clk), .rst(rst), .take(accept), .cur(seq_cur)
  );

  wflow_link_out #(.CMD_W(CMD_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
                   .ADDR_W(ADDR_W), .DW(DATA_W)) snp_link_i (
    .clk(clk), .rst(rst), .load(load_snp),
    .cmd_i(CMD_W'(CMD_SNP_WR)), .tag_i(MY_TAG), .seq_i(seq_cur),
    .addr_i(cpu_req_addr), .data_i(cpu_req_data),
    .valid_o(snp_req_valid), .cmd_o(snp_req_cmd), .tag_o(snp_req_tag),
    .seq_o(snp_req_seq), .addr_o(snp_req_addr), .data_o(snp_req_data)
  );

  wflow_link_out #(.CMD_W(CMD_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
                   .ADDR_W(ADDR_W), .DW(LINE_W)) bus_link_i (
    .clk(clk), .rst(rst), .load(load_bus),
    .cmd_i(CMD_W'(CMD_BUS_WR)), .tag_i(MY_TAG), .seq_i(seq_q),
    .addr_i(addr_q), .data_i(line),
    .valid_o(bus_req_valid), .cmd_o(bus_req_cmd), .tag_o(bus_req_tag),
    .seq_o(bus_req_seq), .addr_o(bus_req_addr), .data_o(bus_req_data)
  );

  wflow_link_out #(.CMD_W(CMD_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
                   .ADDR_W(ADDR_W), .DW(DATA_W)) cpu_link_i (
    .clk(clk), .rst(rst), .load(load_cpu),
    .cmd_i(CMD_W'(CMD_WR_RSP)), .tag_i(MY_TAG), .seq_i(rsp_seq),
    .addr_i(rsp_addr), .data_i(rsp_data),
    .valid_o(cpu_rsp_valid), .cmd_o(cpu_rsp_cmd), .tag_o(cpu_rsp_tag),
    .seq_o(cpu_rsp_seq), .addr_o(cpu_rsp_addr), .data_o(cpu_rsp_data)
  );
endmodule

// File: rtl/wflow_seq_chk.sv
module wflow_seq_chk #(
  parameter int CORE_ID = 0,
  parameter int ADDR_W  = 32,
  parameter int CMD_W   = 8,
  parameter int TAG_W   = 8,
  parameter int SEQ_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_req_hit,
  input logic              snp_req_valid,
  input logic [ADDR_W-1:0] snp_req_addr,
  input logic [SEQ_W-1:0]  snp_req_seq,
  input logic              snp_rsp_valid,
  input logic              snp_rsp_hit,
  input logic              bus_req_valid,
  input logic [SEQ_W-1:0]  bus_req_seq,
  input logic              bus_rsp_valid,
  input logic              cpu_rsp_valid,
  input logic [CMD_W-1:0]  cpu_rsp_cmd,
  input logic [TAG_W-1:0]  cpu_rsp_tag
);
  logic             snp_wait, bus_wait;
  logic [SEQ_W-1:0] snp_seen_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_wait     <= 1'b0;
      bus_wait     <= 1'b0;
      snp_seen_seq <= '0;
    end else begin
      if (snp_req_valid) begin
        snp_wait     <= 1'b1;
        snp_seen_seq <= snp_req_seq;
      end else if (snp_rsp_valid) begin
        snp_wait     <= 1'b0;
      end
      if (bus_req_valid)      bus_wait <= 1'b1;
      else if (bus_rsp_valid) bus_wait <= 1'b0;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cpu_req_ready && !cpu_rsp_valid && !snp_req_valid && !bus_req_valid);

  a_r2_hit_answers: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && cpu_req_hit) |=>
      cpu_rsp_valid && (cpu_rsp_cmd == 8'h12) && !snp_req_valid && !bus_req_valid);

  a_r3_miss_snoops: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && !cpu_req_hit) |=>
      snp_req_valid && (snp_req_addr == $past(cpu_req_addr)) && !cpu_rsp_valid);

  a_r4_snoop_hit_answers: assert property (@(posedge clk) disable iff (rst)
    (snp_wait && snp_rsp_valid && snp_rsp_hit) |=> cpu_rsp_valid && !bus_req_valid);

  a_r5_snoop_miss_to_bus: assert property (@(posedge clk) disable iff (rst)
    (snp_wait && snp_rsp_valid && !snp_rsp_hit) |=> bus_req_valid && !cpu_rsp_valid);

  a_r5_bus_done_answers: assert property (@(posedge clk) disable iff (rst)
    (bus_wait && bus_rsp_valid) |=> cpu_rsp_valid);

  a_r6_rsp_tag: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> (cpu_rsp_tag == TAG_W'(CORE_ID)));

  a_r7_bus_seq_matches: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> (bus_req_seq == snp_seen_seq));

  a_r8_busy_holds_off: assert property (@(posedge clk) disable iff (rst)
    (snp_req_valid || snp_wait || bus_req_valid || bus_wait) |-> !cpu_req_ready);

  a_r10_one_link: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_rsp_valid, snp_req_valid, bus_req_valid}));
endmodule

bind wflow_seq wflow_seq_chk #(
  .CORE_ID(CORE_ID), .ADDR_W(ADDR_W), .CMD_W(CMD_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W)
) chk_i (
  .clk(clk), .rst(rst),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_addr(cpu_req_addr), .cpu_req_hit(cpu_req_hit),
  .snp_req_valid(snp_req_valid), .snp_req_addr(snp_req_addr), .snp_req_seq(snp_req_seq),
  .snp_rsp_valid(snp_rsp_valid), .snp_rsp_hit(snp_rsp_hit),
  .bus_req_valid(bus_req_valid), .bus_req_seq(bus_req_seq),
  .bus_rsp_valid(bus_rsp_valid),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_cmd(cpu_rsp_cmd), .cpu_rsp_tag(cpu_rsp_tag)
);

// File: tb/wflow_seq_tb.sv
`timescale 1ns/1ps
module wflow_seq_tb_top;
  localparam int CID = 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req_valid = 1'b0, cpu_req_hit = 1'b0;
  logic [31:0]  cpu_req_addr = '0, cpu_req_data = '0;
  logic         cpu_req_ready;
  logic         snp_req_valid;
  logic [7:0]   snp_req_cmd, snp_req_tag, snp_req_seq, snp_req_peer;
  logic [31:0]  snp_req_addr, snp_req_data;
  logic         snp_rsp_valid = 1'b0, snp_rsp_hit = 1'b0;
  logic         bus_req_valid;
  logic [7:0]   bus_req_cmd, bus_req_tag, bus_req_seq;
  logic [31:0]  bus_req_addr;
  logic [511:0] bus_req_data;
  logic         bus_rsp_valid = 1'b0;
  logic         cpu_rsp_valid;
  logic [7:0]   cpu_rsp_cmd, cpu_rsp_tag, cpu_rsp_seq;
  logic [31:0]  cpu_rsp_addr, cpu_rsp_data;
  logic         st_local_hit, st_snoop_hit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] exp_seq = 8'd0;

  always #10 clk = ~clk;

  wflow_seq #(.CORE_ID(CID)) dut_i (.*);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [511:0] line_of(input logic [31:0] a, input logic [31:0] d);
    logic [511:0] l = '0;
    l[a[5:2]*32 +: 32] = d;
    return l;
  endfunction

  // accept a request; returns at the negedge after the accepting edge
  task automatic send_req(input logic [31:0] a, input logic [31:0] d, input bit hit);
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_data = d; cpu_req_hit = hit;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic check_rsp(input string rq, input logic [31:0] a, input logic [31:0] d);
    check(cpu_rsp_valid == 1'b1, rq, "cpu_rsp_valid", cpu_rsp_valid, 1);
    check(cpu_rsp_cmd == 8'h12, rq, "cpu_rsp_cmd", cpu_rsp_cmd, 8'h12);
    check(cpu_rsp_tag == 8'(CID), "R6", "cpu_rsp_tag", cpu_rsp_tag, CID);
    check(cpu_rsp_seq == exp_seq, "R7", "cpu_rsp_seq", cpu_rsp_seq, exp_seq);
    check(cpu_rsp_addr == a && cpu_rsp_data == d, rq, "cpu_rsp addr/data",
          {cpu_rsp_addr, cpu_rsp_data}, {a, d});
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(cpu_req_ready && !snp_req_valid && !bus_req_valid && !cpu_rsp_valid,
          "R1", "ready/valids", {cpu_req_ready, snp_req_valid, bus_req_valid, cpu_rsp_valid}, 4'b1000);
    check(!st_local_hit && !st_snoop_hit, "R1", "status", {st_local_hit, st_snoop_hit}, 0);
  endtask

  task automatic t_local_hit(input logic [31:0] a, input logic [31:0] d);
    send_req(a, d, 1'b1);
    check_rsp("R2", a, d);
    check(!snp_req_valid && !bus_req_valid, "R2", "no snoop/bus", {snp_req_valid, bus_req_valid}, 0);
    check(st_local_hit == 1'b1, "R9", "st_local_hit", st_local_hit, 1);
    @(negedge clk);
    check(!cpu_rsp_valid, "R10", "cpu_rsp pulse width", cpu_rsp_valid, 0);
    exp_seq++;
  endtask

  task automatic t_snoop_hit(input logic [31:0] a, input logic [31:0] d);
    send_req(a, d, 1'b0);
    check(snp_req_valid && snp_req_cmd == 8'h21, "R3", "snoop valid/cmd", {snp_req_valid, snp_req_cmd}, {1'b1, 8'h21});
    check(snp_req_peer == 8'd0, "R3", "snp_req_peer", snp_req_peer, 0);
    check(snp_req_addr == a && snp_req_data == d, "R3", "snoop addr/data", {snp_req_addr, snp_req_data}, {a, d});
    check(snp_req_tag == 8'(CID), "R6", "snp_req_tag", snp_req_tag, CID);
    check(snp_req_seq == exp_seq, "R7", "snp_req_seq", snp_req_seq, exp_seq);
    check(!cpu_req_ready && !st_local_hit && !st_snoop_hit, "R8", "busy, status",
          {cpu_req_ready, st_local_hit, st_snoop_hit}, 0);
    // stray request while busy must be ignored
    cpu_req_valid = 1'b1; cpu_req_hit = 1'b1; cpu_req_addr = 32'hDEAD_0000;
    @(negedge clk);
    check(!snp_req_valid && !cpu_rsp_valid, "R10", "no repeat pulses", {snp_req_valid, cpu_rsp_valid}, 0);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check(!cpu_req_ready && !cpu_rsp_valid, "R8", "still busy", {cpu_req_ready, cpu_rsp_valid}, 0);
    snp_rsp_valid = 1'b1; snp_rsp_hit = 1'b1;
    @(negedge clk);
    snp_rsp_valid = 1'b0;
    check_rsp("R4", a, d);
    check(!bus_req_valid && cpu_req_ready, "R4", "no bus, ready", {bus_req_valid, cpu_req_ready}, 1);
    check(st_snoop_hit == 1'b1, "R9", "st_snoop_hit", st_snoop_hit, 1);
    exp_seq++;
  endtask

  task automatic t_double_miss(input logic [31:0] a, input logic [31:0] d);
    send_req(a, d, 1'b0);
    check(snp_req_valid && snp_req_seq == exp_seq, "R3", "snoop issued", {snp_req_valid, snp_req_seq}, {1'b1, exp_seq});
    @(negedge clk);
    snp_rsp_valid = 1'b1; snp_rsp_hit = 1'b0;
    @(negedge clk);
    snp_rsp_valid = 1'b0;
    check(bus_req_valid && bus_req_cmd == 8'h31, "R5", "bus valid/cmd", {bus_req_valid, bus_req_cmd}, {1'b1, 8'h31});
    check(bus_req_addr == a, "R5", "bus addr", bus_req_addr, a);
    check(bus_req_data == line_of(a, d), "R5", "bus line", bus_req_data, line_of(a, d));
    check(bus_req_tag == 8'(CID) && bus_req_seq == exp_seq, "R7", "bus tag/seq",
          {bus_req_tag, bus_req_seq}, {8'(CID), exp_seq});
    check(!cpu_rsp_valid && !cpu_req_ready && !st_snoop_hit, "R8", "waiting on bus",
          {cpu_rsp_valid, cpu_req_ready, st_snoop_hit}, 0);
    repeat (3) @(negedge clk);
    check(!bus_req_valid && !cpu_req_ready, "R10", "bus pulse, busy", {bus_req_valid, cpu_req_ready}, 0);
    bus_rsp_valid = 1'b1;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
    check_rsp("R5", a, d);
    check(cpu_req_ready, "R8", "ready after response", cpu_req_ready, 1);
    exp_seq++;
  endtask

  task automatic t_seq_wrap;
    for (int i = 0; i < 256; i++) begin
      send_req(32'h1000 + 32'(i * 4), 32'(i), 1'b1);
      check(cpu_rsp_valid && cpu_rsp_seq == exp_seq, "R7", "seq sequence", cpu_rsp_seq, exp_seq);
      exp_seq++;
    end
  endtask

  initial begin
    t_reset();
    t_local_hit(32'h0000_1234, 32'hA5A5_0001);
    t_snoop_hit(32'h0000_2040, 32'h1111_2222);
    t_double_miss(32'h0000_3000, 32'hCAFE_0001);
    t_double_miss(32'h0000_40FC, 32'hBEEF_0002);
    t_local_hit(32'h0000_5008, 32'h0000_0042);
    t_seq_wrap();
    t_snoop_hit(32'h0000_6010, 32'h7777_8888);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule